// File: doc/BRIEF.md
# Interval-Paced Overlay Input Feeder

This block owns the input queue of a linear chain of pipelined functional units. Stream words arrive on a write strobe and are stored in an internal queue. A phase counter, programmed with the initiation interval minus one, decides when words leave: one word per interval while the queue holds data. The same counter stops feeding once a programmed number of words has gone out. Each word that leaves is presented with a valid flag one clock after it is taken. A completion flag reports that the programmed run has finished.

Software-side setup uses two load strobes: one sets the interval value, one sets the run length. Loading a run length restarts the tally and clears completion. Two functional-unit strobes (instruction load and register write enable) and a register data word are relayed to the unit chain with a one-clock delay. That delay is a parameter option and is on by default.

Top module: `ii_paced_feeder`

## Requirements
- R1: While reset is held, valid_o, done_o, full_o, instr_load_o and reg_wren_o are 0 and empty_o is 1. The interval value and the run length are both reset to 0.
- R2: A word is stored on every clock edge at which wr_en_i is 1 and the queue is not full. full_o is 1 while DEPTH words are held. A write while full is dropped and changes no stored word.
- R3: With interval value P loaded and data always present, the words of a run leave exactly P+1 clocks apart. The first read of a run happens in the first cycle that the queue is non-empty, so valid_o rises one edge after the edge that stored the first word.
- R4: With interval value 0, a word leaves on every cycle in which the queue is non-empty and the run is unfinished. valid_o can be 1 on two successive edges only when the value in force was 0.
- R5: rd_data_o carries the stored words in write order. It is meaningful on the edges where valid_o is 1, one edge after the read.
- R6: When the queue runs dry in a run, the phase counter rests at zero. The next word stored is read in the following cycle, so valid_o is 0 at the first edge after the store and 1 at the second.
- R7: After the number of reads equals the run length, no further reads occur and done_o is 1. done_o rises on the same edge as the last valid_o of the run.
- R8: A run-length load clears the read tally and done_o. It blocks the read in its own cycle, so valid_o is 0 on the next edge. If data is waiting, the next read follows in the cycle after the load.
- R9: A run length of 0 issues no reads, and done_o stays 0.
- R10: instr_load_o, reg_wren_o and reg_data_o equal instr_load_i, reg_wren_i and reg_data_i of the previous clock.
- R11: No read is issued while the queue is empty. valid_o never reports a word that was not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Store strobe for the queue |
| wr_data_i | input | DW | Word to store |
| cfg_ii_we_i | input | 1 | Load strobe for the interval value |
| cfg_ii_i | input | IIW | Interval minus one |
| cfg_len_we_i | input | 1 | Load strobe for the run length; restarts the run |
| cfg_len_i | input | CW | Number of words in the run |
| instr_load_i | input | 1 | Instruction-load strobe toward the units |
| reg_wren_i | input | 1 | Register-write strobe toward the units |
| reg_data_i | input | DW | Register data toward the units |
| rd_data_o | output | DW | Word leaving the queue |
| valid_o | output | 1 | rd_data_o holds a new word |
| done_o | output | 1 | Run length reached |
| full_o | output | 1 | Queue holds DEPTH words |
| empty_o | output | 1 | Queue holds no words |
| instr_load_o | output | 1 | Relayed instruction-load strobe |
| reg_wren_o | output | 1 | Relayed register-write strobe |
| reg_data_o | output | DW | Relayed register data |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a store and a paced read. The sweep over interval values 0 to 4 stores words back to back while reads run, so with a zero interval the queue is written and read on every cycle. Those cases are judged by word order against a queue model in the bench and by exact spacing between valid words. The second pair is a run-length load and a due read. The bench times a load onto the exact cycle a read is scheduled. It then expects no valid on the following edge, done cleared, and the held word appearing one edge later.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

   typedef struct packed {
      logic ld;
      logic wren;
   } strobe_t;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ff_store.sv
module ff_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [DW-1:0] din_i,
   input  logic          pop_i,
   output logic [DW-1:0] dout_o,
   output logic          dvalid_o,
   output logic          full_o,
   output logic          empty_o
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CNTW = AW + 1;

   logic [DW-1:0]   mem [DEPTH];
   logic [AW-1:0]   wp_q, rp_q;
   logic [CNTW-1:0] occ_q;
   logic            push_ok, pop_ok;

   assign full_o  = (occ_q == CNTW'(DEPTH));
   assign empty_o = (occ_q == '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q     <= '0;
         rp_q     <= '0;
         occ_q    <= '0;
         dout_o   <= '0;
         dvalid_o <= 1'b0;
      end else begin
         dvalid_o <= pop_ok;
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok) begin
            rp_q   <= rp_q + 1'b1;
            dout_o <= mem[rp_q];
         end
         unique case ({push_ok, pop_ok})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end
endmodule

// File: rtl/ii_pacer.sv
module ii_pacer #(
   parameter int IIW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [IIW-1:0] ii_i,
   input  logic           go_i,
   output logic           pop_o,
   output logic [IIW-1:0] phase_o
);
   logic [IIW-1:0] ph_q, ph_d;

   assign pop_o   = (ph_q == '0) && go_i;
   assign phase_o = ph_q;

   always_comb begin
      if (ph_q != '0) begin
         ph_d = (ph_q >= ii_i) ? '0 : ph_q + 1'b1;
      end else if (pop_o) begin
         ph_d = (ii_i == '0) ? '0 : IIW'(1);
      end else begin
         ph_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_d;
   end
endmodule

// File: rtl/run_tally.sv
module run_tally #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] limit_i,
   input  logic          pop_i,
   output logic          armed_o,
   output logic          done_o
);
   logic [CW-1:0] limit_q, tally_q;

   assign armed_o = (tally_q != limit_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '0;
         tally_q <= '0;
         done_o  <= 1'b0;
      end else if (load_i) begin
         limit_q <= limit_i;
         tally_q <= '0;
         done_o  <= 1'b0;
      end else if (pop_i) begin
         tally_q <= tally_q + 1'b1;
         if (tally_q + 1'b1 == limit_q) done_o <= 1'b1;
      end
   end
endmodule

// File: rtl/strobe_relay.sv
module strobe_relay
   import feeder_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  strobe_t       stb_i,
   input  logic [DW-1:0] data_i,
   output strobe_t       stb_o,
   output logic [DW-1:0] data_o
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stb_o  <= '0;
               data_o <= '0;
            end else begin
               stb_o  <= stb_i;
               data_o <= data_i;
            end
         end
      end else begin : g_wire
         assign stb_o  = stb_i;
         assign data_o = data_i;
      end
   endgenerate
endmodule

// File: rtl/ii_paced_feeder.sv
module ii_paced_feeder
   import feeder_pkg::*;
#(
   parameter int DW        = 32,
   parameter int DEPTH     = 16,
   parameter int CW        = 16,
   parameter int IIW       = 4,
   parameter bit RELAY_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en_i,
   input  logic [DW-1:0]  wr_data_i,
   input  logic           cfg_ii_we_i,
   input  logic [IIW-1:0] cfg_ii_i,
   input  logic           cfg_len_we_i,
   input  logic [CW-1:0]  cfg_len_i,
   input  logic           instr_load_i,
   input  logic           reg_wren_i,
   input  logic [DW-1:0]  reg_data_i,
   output logic [DW-1:0]  rd_data_o,
   output logic           valid_o,
   output logic           done_o,
   output logic           full_o,
   output logic           empty_o,
   output logic           instr_load_o,
   output logic           reg_wren_o,
   output logic [DW-1:0]  reg_data_o
);
   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
      if (DW < 1 || CW < 1 || IIW < 1) begin : g_bad_width
         $error("DW, CW and IIW must be at least 1");
      end
   endgenerate

   logic [IIW-1:0] ii_q;
   logic [IIW-1:0] phase_w;
   logic           pop_w, armed_w, go_w;
   strobe_t        stb_in, stb_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ii_q <= '0;
      else if (cfg_ii_we_i) ii_q <= cfg_ii_i;
   end

   assign go_w = armed_w && !empty_o && !cfg_len_we_i;

   ff_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n),
      .push_i(wr_en_i), .din_i(wr_data_i),
      .pop_i(pop_w), .dout_o(rd_data_o), .dvalid_o(valid_o),
      .full_o(full_o), .empty_o(empty_o)
   );

   ii_pacer #(.IIW(IIW)) pacer_i (
      .clk(clk), .rst_n(rst_n),
      .ii_i(ii_q), .go_i(go_w),
      .pop_o(pop_w), .phase_o(phase_w)
   );

   run_tally #(.CW(CW)) tally_i (
      .clk(clk), .rst_n(rst_n),
      .load_i(cfg_len_we_i), .limit_i(cfg_len_i),
      .pop_i(pop_w), .armed_o(armed_w), .done_o(done_o)
   );

   assign stb_in.ld   = instr_load_i;
   assign stb_in.wren = reg_wren_i;

   strobe_relay #(.DW(DW), .REGISTERED(RELAY_REG)) relay_i (
      .clk(clk), .rst_n(rst_n),
      .stb_i(stb_in), .data_i(reg_data_i),
      .stb_o(stb_out), .data_o(reg_data_o)
   );

   assign instr_load_o = stb_out.ld;
   assign reg_wren_o   = stb_out.wren;
endmodule

// File: rtl/ii_paced_feeder_chk.sv
module ii_paced_feeder_chk #(
   parameter int IIW       = 4,
   parameter bit RELAY_REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           valid_o,
   input logic           empty_o,
   input logic           done_o,
   input logic           cfg_len_we_i,
   input logic [IIW-1:0] ii_q,
   input logic [IIW-1:0] phase_w,
   input logic           instr_load_i,
   input logic           reg_wren_i,
   input logic           instr_load_o,
   input logic           reg_wren_o
);
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 1'b1;
   end

   // R11
   no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd1 && valid_o) |-> $past(!empty_o));

   // R7
   halt_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !cfg_len_we_i) |=> !valid_o);

   // R8
   reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_len_we_i |=> (!valid_o && !done_o));

   // R4
   back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && valid_o && $past(valid_o)) |-> ($past(ii_q, 2) == '0));

   // R6
   rest_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_w == '0 && empty_o) |=> (phase_w == '0));

   generate
      if (RELAY_REG) begin : g_relay
         // R10
         relay_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd1) |-> (instr_load_o == $past(instr_load_i) &&
                                 reg_wren_o == $past(reg_wren_i)));
      end
   endgenerate
endmodule

bind ii_paced_feeder ii_paced_feeder_chk #(.IIW(IIW), .RELAY_REG(RELAY_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .empty_o(empty_o),
   .done_o(done_o), .cfg_len_we_i(cfg_len_we_i), .ii_q(ii_q), .phase_w(phase_w),
   .instr_load_i(instr_load_i), .reg_wren_i(reg_wren_i),
   .instr_load_o(instr_load_o), .reg_wren_o(reg_wren_o)
);

// File: tb/ii_paced_feeder_tb_top.sv
module ii_paced_feeder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8, DEPTH = 8, CW = 6, IIW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en_i = 0, cfg_ii_we_i = 0, cfg_len_we_i = 0;
   logic instr_load_i = 0, reg_wren_i = 0;
   logic [DW-1:0] wr_data_i = '0, reg_data_i = '0;
   logic [IIW-1:0] cfg_ii_i = '0;
   logic [CW-1:0] cfg_len_i = '0;
   logic [DW-1:0] rd_data_o, reg_data_o;
   logic valid_o, done_o, full_o, empty_o, instr_load_o, reg_wren_o;

   ii_paced_feeder #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .IIW(IIW)) dut_i (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0, nbad = 0, cyc = 0;
   int cv = 0, first_c = 0, last_c = 0, gmin = 0, gmax = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] seq = 8'h30;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && valid_o) begin
         if (exp_q.size() == 0) begin
            check(0, "R11 valid with nothing stored", 1, 0);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            check(rd_data_o == e, "R5 word order", rd_data_o, e);
         end
         if (cv > 0) begin
            int g;
            g = cyc - last_c;
            if (cv == 1 || g < gmin) gmin = g;
            if (cv == 1 || g > gmax) gmax = g;
         end else first_c = cyc;
         last_c = cyc;
         cv++;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic prog_ii(input int p);
      cfg_ii_i = IIW'(p); cfg_ii_we_i = 1; tick(); cfg_ii_we_i = 0;
   endtask

   task automatic prog_len(input int n);
      cv = 0; gmin = 0; gmax = 0; first_c = 0;
      cfg_len_i = CW'(n); cfg_len_we_i = 1; tick(); cfg_len_we_i = 0;
   endtask

   task automatic push(input bit keep);
      wr_data_i = seq; wr_en_i = 1;
      if (keep) exp_q.push_back(seq);
      seq = seq + 8'd7;
      tick(); wr_en_i = 0;
   endtask

   task automatic run_case(input int p, input int n, input int k);
      int e, left, c0;
      prog_ii(p);
      prog_len(n);
      push(1);
      c0 = cyc;
      for (int i = 1; i < k; i++) push(1);
      idle((p + 1) * (k + 1) + 6);
      e = (n < k) ? n : k;
      check(first_c == c0 + 1, "R3 first read timing", first_c, c0 + 1);
      check(cv == e, "R7 words per run", cv, e);
      if (e > 1) begin
         check(gmin == p + 1 && gmax == p + 1, (p == 0) ? "R4 spacing" : "R3 spacing",
               gmax, p + 1);
      end
      check(done_o == (k >= n), "R7 done flag", done_o, (k >= n));
      left = k - e;
      if (left > 0) begin
         prog_len(left);
         c0 = cyc;
         idle((p + 1) * (left + 1) + 4);
         check(first_c == c0 + 1, "R8 restart read timing", first_c, c0 + 1);
         check(cv == left && done_o == 1, "R8 drain run", cv, left);
      end
      check(empty_o == 1, "R2 queue drained", empty_o, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         nchk++; nbad++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      int nset[3] = '{1, 3, 6};
      int kset[2] = '{2, 5};
      idle(3);
      // R1
      check(valid_o == 0 && done_o == 0 && full_o == 0, "R1 reset outputs",
            {valid_o, done_o, full_o}, 0);
      check(empty_o == 1 && instr_load_o == 0 && reg_wren_o == 0, "R1 reset empty/strobes",
            {empty_o, instr_load_o, reg_wren_o}, 4);
      rst_n = 1;
      idle(2);

      // R10 relayed strobes
      instr_load_i = 1; reg_wren_i = 1; reg_data_i = 8'h5A;
      #1 check(instr_load_o == 0 && reg_wren_o == 0, "R10 not yet relayed", instr_load_o, 0);
      tick();
      check(instr_load_o == 1 && reg_wren_o == 1 && reg_data_o == 8'h5A,
            "R10 relayed after one clock", reg_data_o, 8'h5A);
      instr_load_i = 0; reg_wren_i = 0; reg_data_i = 8'h00;
      tick();
      check(instr_load_o == 0 && reg_wren_o == 0, "R10 strobes released", instr_load_o, 0);

      // sweep: interval 0..4, run lengths, burst sizes
      for (int p = 0; p <= 4; p++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 2; b++)
               run_case(p, nset[a], kset[b]);

      // R9 zero length, R2 overflow drop
      prog_len(0);
      for (int i = 0; i < DEPTH + 2; i++) push(i < DEPTH);
      idle(3);
      check(cv == 0, "R9 no reads at zero length", cv, 0);
      check(done_o == 0, "R9 done stays low", done_o, 0);
      check(full_o == 1, "R2 full flag", full_o, 1);
      prog_ii(0);
      prog_len(DEPTH + 2);
      idle(DEPTH + 6);
      check(cv == DEPTH, "R2 extra writes dropped", cv, DEPTH);
      check(empty_o == 1 && done_o == 0, "R2 queue empty, run short", done_o, 0);
      prog_len(0);

      // R6 queue runs dry mid-run
      prog_ii(2);
      prog_len(3);
      push(1);
      idle(8);
      check(empty_o == 1 && done_o == 0 && cv == 1, "R6 dry mid-run", cv, 1);
      push(1);
      check(valid_o == 0, "R6 no valid on first edge after store", valid_o, 0);
      tick();
      check(valid_o == 1, "R6 valid on second edge after store", valid_o, 1);
      idle(5);
      push(1);
      idle(4);
      check(cv == 3 && done_o == 1, "R7 done after refill run", cv, 3);

      // R8 load lands on a due read
      prog_ii(3);
      prog_len(10);
      push(1); push(1); push(1);
      idle(2);
      prog_len(10);
      check(valid_o == 0 && done_o == 0, "R8 read blocked in load cycle", valid_o, 0);
      tick();
      check(valid_o == 1, "R8 held word follows load", valid_o, 1);
      idle(8);
      check(cv == 2 && done_o == 0 && empty_o == 1, "R8 rest of run", cv, 2);
      prog_len(0);
      idle(2);
      check(exp_q.size() == 0, "R5 all stored words delivered", exp_q.size(), 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule